// File: doc/BRIEF.md
# Flash Segment Window Decoder

This block maps a flat bus address space onto several serial flash chips. It holds one segment register for each chip select. Each register gives a lower and an upper bound for that chip's window, counted in 8 MB units. Every decode request carries a bus address. One cycle later the block returns three things: whether any open window contains the address, which chip select owns it, and the byte offset of the address from the start of that window. The byte offset is the address that goes to the flash.

Software programs the windows through a simple register port. Writes are registered, and reads are combinational. The intended layout is contiguous: each window starts where the previous one ends, and all windows stay inside the total window limit. The block still decodes sensibly when that rule is broken. A window whose lower bound is not below its upper bound is treated as closed. When windows overlap, the lowest chip select takes the address. Writes that would push a bound past the total limit are refused. A write that would make the first chip's window 128 MB or larger is also refused.

Top module: `seg_window_decoder`

## Requirements
- R1: After reset every segment register reads 0x00000000, so every window is closed, dec_valid is low, and any decode reports a miss.
- R2: The segment register of chip select k is at byte offset 0x30 + 4*k. The upper bound (in 8 MB units) is in bits [31:24] and the lower bound is in bits [23:16]. Bits [15:0] always read zero, even when written with ones.
- R3: A write to any offset outside the segment registers (for example 0x2C, or 0x3C with three chip selects) changes nothing. A read of such an offset returns zero.
- R4: A window whose lower bound is greater than or equal to its upper bound never produces a hit.
- R5: A decode request is answered on the cycle after it is accepted (dec_valid high). The block reports a hit with dec_cs = k when lower_k*8 MB <= address < upper_k*8 MB, and dec_offset = address - lower_k*8 MB.
- R6: When several open windows contain the address, the lowest-numbered chip select is reported.
- R7: A write whose lower or upper bound exceeds LIMIT_UNITS (default 32, that is 256 MB) is refused, and the register keeps its previous value. A bound equal to LIMIT_UNITS is accepted.
- R8: A write to chip select 0 that would open a window spanning more than CS0_MAX_UNITS units (default 15, that is 120 MB) is refused. A closed window written to chip select 0 is accepted whatever its bounds.
- R9: On a miss, dec_hit, dec_cs and dec_offset are all zero.
- R10: A decode accepted in the same cycle as a segment register write uses the register contents from before the write. The next decode sees the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Byte offset of the register write |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 8 | Byte offset of the register read |
| reg_rd_data | output | 32 | Combinational register read data |
| dec_req | input | 1 | Decode request |
| dec_addr | input | 32 | Bus address to decode |
| dec_valid | output | 1 | Decode result valid, one cycle after dec_req |
| dec_hit | output | 1 | Address falls in an open window |
| dec_cs | output | 2 | Chip select that owns the address |
| dec_offset | output | 32 | Byte offset inside the selected window |

## Verification
A segment register write and a decode can land on the same clock edge, and the decode must then see the old window bounds. The bench provokes this by driving a write that moves chip select 0's upper bound in the same cycle as a decode of an address just beyond the old bound. The scoreboard expects the result predicted from the register model before the write. A second decode of the same address in the following cycle must reflect the new bound.

// File: rtl/seg_pkg.sv
// Shared types for the segment window decoder.
// Assumes bounds are 8-bit counts of fixed-size address units.
package seg_pkg;

    typedef struct packed {
        logic [7:0] hi_u;   // exclusive upper bound, in units
        logic [7:0] lo_u;   // inclusive lower bound, in units
    } seg_bounds_t;

    // Pack bounds into the register read format (low half zero).
    function automatic logic [31:0] seg_to_word(seg_bounds_t b);
        return {b.hi_u, b.lo_u, 16'h0000};
    endfunction

endpackage

// File: rtl/seg_regfile.sv
// Segment register storage with write screening.
// Holds one bounds pair per chip select at consecutive word offsets from
// REG_BASE. Refuses writes whose bounds exceed LIMIT_UNITS, and refuses
// chip select 0 writes that open a window wider than CS0_MAX_UNITS.
// Assumes REG_BASE is word aligned.
module seg_regfile
    import seg_pkg::*;
#(
    parameter int NUM_CS        = 3,
    parameter int REG_AW        = 8,
    parameter int REG_BASE      = 'h30,
    parameter int LIMIT_UNITS   = 32,
    parameter int CS0_MAX_UNITS = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [REG_AW-1:0]        wr_addr,
    input  logic [31:0]              wr_data,
    input  logic [REG_AW-1:0]        rd_addr,
    output logic [31:0]              rd_data,
    output seg_bounds_t [NUM_CS-1:0] bounds
);

    localparam int WW = REG_AW - 2;
    localparam logic [WW-1:0] BASE_W  = WW'(REG_BASE >> 2);
    localparam logic [WW-1:0] COUNT_W = WW'(NUM_CS);
    localparam logic [7:0]    LIM8    = 8'(LIMIT_UNITS);
    localparam logic [7:0]    CS0M8   = 8'(CS0_MAX_UNITS);

    logic [WW-1:0] wr_rel, rd_rel;
    logic          wr_in, rd_in;
    seg_bounds_t   wr_b;
    logic          wr_in_limit;

    // Word index relative to the first segment register, and range test.
    always_comb begin
        wr_rel = wr_addr[REG_AW-1:2] - BASE_W;
        rd_rel = rd_addr[REG_AW-1:2] - BASE_W;
        wr_in  = (wr_addr[REG_AW-1:2] >= BASE_W) && (wr_rel < COUNT_W);
        rd_in  = (rd_addr[REG_AW-1:2] >= BASE_W) && (rd_rel < COUNT_W);
        wr_b   = '{hi_u: wr_data[31:24], lo_u: wr_data[23:16]};
        wr_in_limit = (wr_b.hi_u <= LIM8) && (wr_b.lo_u <= LIM8);
    end

    for (genvar k = 0; k < NUM_CS; k++) begin : g_seg
        logic accept;

        // Decide whether this register takes the current write.
        if (k == 0) begin : g_first
            always_comb
                accept = wr_en && wr_in && (wr_rel == WW'(k)) && wr_in_limit &&
                         ((wr_b.lo_u >= wr_b.hi_u) ||
                          ((wr_b.hi_u - wr_b.lo_u) <= CS0M8));
        end else begin : g_rest
            always_comb
                accept = wr_en && wr_in && (wr_rel == WW'(k)) && wr_in_limit;
        end

        // Bounds storage, cleared (closed) by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bounds[k] <= '0;
            else if (accept)
                bounds[k] <= wr_b;
        end

        assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_in && wr_rel == WW'(k) &&
             (wr_data[31:24] > LIM8 || wr_data[23:16] > LIM8))
            |=> $stable(bounds[k]));

        assert_bounds_in_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
            bounds[k].hi_u <= LIM8 && bounds[k].lo_u <= LIM8);

        if (k == 0) begin : g_chk0
            assert_first_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (bounds[0].lo_u < bounds[0].hi_u)
                |-> ((bounds[0].hi_u - bounds[0].lo_u) <= CS0M8));
        end
    end

    // Combinational readback; unmapped offsets read zero.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_CS; k++)
            if (rd_in && rd_rel == WW'(k))
                rd_data = seg_to_word(bounds[k]);
    end

endmodule

// File: rtl/seg_match.sv
// Per-chip-select window comparators.
// Raises match[k] when the address unit lies in [lo_k, hi_k). A closed
// window (lo >= hi) can never satisfy both compares. Assumes
// ADDR_W - UNIT_SHIFT >= 8.
module seg_match
    import seg_pkg::*;
#(
    parameter int NUM_CS     = 3,
    parameter int ADDR_W     = 32,
    parameter int UNIT_SHIFT = 23
) (
    input  logic [ADDR_W-1:0]        addr,
    input  seg_bounds_t [NUM_CS-1:0] bounds,
    output logic [NUM_CS-1:0]        match
);

    localparam int UW = ADDR_W - UNIT_SHIFT;

    logic [UW-1:0] unit;
    assign unit = addr[ADDR_W-1:UNIT_SHIFT];

    for (genvar k = 0; k < NUM_CS; k++) begin : g_cmp
        // Containment test for one window.
        always_comb
            match[k] = (unit >= {{(UW-8){1'b0}}, bounds[k].lo_u}) &&
                       (unit <  {{(UW-8){1'b0}}, bounds[k].hi_u});
    end

endmodule

// File: rtl/seg_prio.sv
// Lowest-index selection and window offset.
// Picks the lowest set bit of match, and subtracts that window's base from
// the address. Outputs zero on a miss.
module seg_prio
    import seg_pkg::*;
#(
    parameter int NUM_CS     = 3,
    parameter int ADDR_W     = 32,
    parameter int UNIT_SHIFT = 23,
    parameter int CS_W       = 2
) (
    input  logic [ADDR_W-1:0]        addr,
    input  seg_bounds_t [NUM_CS-1:0] bounds,
    input  logic [NUM_CS-1:0]        match,
    output logic                     hit,
    output logic [CS_W-1:0]          cs,
    output logic [ADDR_W-1:0]        offset
);

    logic [7:0] base_u;

    // Scan from the top so the lowest matching index is written last.
    always_comb begin
        hit    = 1'b0;
        cs     = '0;
        base_u = '0;
        for (int k = NUM_CS - 1; k >= 0; k--) begin
            if (match[k]) begin
                hit    = 1'b1;
                cs     = CS_W'(k);
                base_u = bounds[k].lo_u;
            end
        end
    end

    // Offset of the address from the selected window base.
    always_comb
        offset = hit ? (addr - ({{(ADDR_W-8){1'b0}}, base_u} << UNIT_SHIFT)) : '0;

endmodule

// File: rtl/seg_window_decoder.sv
// Top level of the segment window decoder.
// Combines the register file, the comparators and the priority pick, and
// registers the decode result for one-cycle latency. A decode that shares
// its cycle with a register write sees the pre-write bounds.
module seg_window_decoder
    import seg_pkg::*;
#(
    parameter int NUM_CS        = 3,
    parameter int ADDR_W        = 32,
    parameter int UNIT_SHIFT    = 23,
    parameter int REG_AW        = 8,
    parameter int REG_BASE      = 'h30,
    parameter int LIMIT_UNITS   = 32,
    parameter int CS0_MAX_UNITS = 15,
    parameter int CS_W          = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_wr_addr,
    input  logic [31:0]       reg_wr_data,
    input  logic [REG_AW-1:0] reg_rd_addr,
    output logic [31:0]       reg_rd_data,
    input  logic              dec_req,
    input  logic [ADDR_W-1:0] dec_addr,
    output logic              dec_valid,
    output logic              dec_hit,
    output logic [CS_W-1:0]   dec_cs,
    output logic [ADDR_W-1:0] dec_offset
);

    seg_bounds_t [NUM_CS-1:0] bounds;
    logic [NUM_CS-1:0]        match;
    logic                     hit_c;
    logic [CS_W-1:0]          cs_c;
    logic [ADDR_W-1:0]        off_c;

    seg_regfile #(
        .NUM_CS(NUM_CS), .REG_AW(REG_AW), .REG_BASE(REG_BASE),
        .LIMIT_UNITS(LIMIT_UNITS), .CS0_MAX_UNITS(CS0_MAX_UNITS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
        .bounds(bounds)
    );

    seg_match #(
        .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT)
    ) u_match (
        .addr(dec_addr), .bounds(bounds), .match(match)
    );

    seg_prio #(
        .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT), .CS_W(CS_W)
    ) u_prio (
        .addr(dec_addr), .bounds(bounds), .match(match),
        .hit(hit_c), .cs(cs_c), .offset(off_c)
    );

    // Result register: capture the decode on request, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_hit    <= 1'b0;
            dec_cs     <= '0;
            dec_offset <= '0;
        end else begin
            dec_valid <= dec_req;
            if (dec_req) begin
                dec_hit    <= hit_c;
                dec_cs     <= cs_c;
                dec_offset <= off_c;
            end
        end
    end

    assert_answer_next_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_req |=> dec_valid);

    assert_miss_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_hit) |-> (dec_cs == '0 && dec_offset == '0));

    assert_pick_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_c |-> match[cs_c]);

    assert_no_lower_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_c |-> ((match & ((NUM_CS'(1) << cs_c) - NUM_CS'(1))) == '0));

endmodule

// File: tb/tb_seg_window_decoder.sv
// Scoreboard bench for seg_window_decoder: decode tasks push predictions
// into a queue, a monitor pops and compares the registered results.
module tb_seg_window_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NCS = 3;
    localparam int LIM = 32;
    localparam int CS0M = 15;

    typedef struct packed {
        logic        hit;
        logic [1:0]  cs;
        logic [31:0] off;
        logic [3:0]  req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [7:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        dec_req = 1'b0;
    logic [31:0] dec_addr = '0;
    logic        dec_valid, dec_hit;
    logic [1:0]  dec_cs;
    logic [31:0] dec_offset;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 0;
    exp_t q[$];
    logic [31:0] m_seg [NCS];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_window_decoder dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .dec_req(dec_req), .dec_addr(dec_addr),
        .dec_valid(dec_valid), .dec_hit(dec_hit), .dec_cs(dec_cs), .dec_offset(dec_offset)
    );

    // Predict a decode from the model registers (lowest index wins).
    function automatic exp_t predict(logic [31:0] a, logic [3:0] rq);
        exp_t r;
        r = '0;
        r.req = rq;
        for (int k = NCS - 1; k >= 0; k--) begin
            logic [7:0] lo, hi;
            lo = m_seg[k][23:16];
            hi = m_seg[k][31:24];
            if (lo < hi && {1'b0, a[31:23]} >= {2'b0, lo} && {1'b0, a[31:23]} < {2'b0, hi}) begin
                r.hit = 1'b1;
                r.cs  = 2'(k);
                r.off = a - ({24'b0, lo} << 23);
            end
        end
        return r;
    endfunction

    // Model update for a write, following R2/R3/R7/R8.
    task automatic model_write(logic [7:0] ba, logic [31:0] d);
        int idx;
        logic [7:0] lo, hi;
        lo = d[23:16];
        hi = d[31:24];
        if (ba < 8'h30 || ba >= 8'(8'h30 + 4 * NCS)) return;
        idx = (int'(ba) - 'h30) / 4;
        if (hi > 8'(LIM) || lo > 8'(LIM)) return;
        if (idx == 0 && lo < hi && (hi - lo) > 8'(CS0M)) return;
        m_seg[idx] = {hi, lo, 16'h0};
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [7:0] ba, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = ba; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        model_write(ba, d);
    endtask

    task automatic reg_check(logic [7:0] ba, string req);
        int idx;
        logic [31:0] exp;
        @(negedge clk);
        reg_rd_addr = ba;
        #1;
        exp = 32'h0;
        if (ba >= 8'h30 && ba < 8'(8'h30 + 4 * NCS)) begin
            idx = (int'(ba) - 'h30) / 4;
            exp = m_seg[idx];
        end
        check(req, reg_rd_data, exp);
    endtask

    task automatic decode(logic [31:0] a, logic [3:0] rq);
        @(negedge clk);
        dec_req = 1'b1; dec_addr = a;
        q.push_back(predict(a, rq));
        @(negedge clk);
        dec_req = 1'b0;
    endtask

    // R10: write and decode on the same edge; prediction uses the old model.
    task automatic write_and_decode(logic [7:0] ba, logic [31:0] d, logic [31:0] a);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = ba; reg_wr_data = d;
        dec_req = 1'b1; dec_addr = a;
        q.push_back(predict(a, 4'd10));
        @(negedge clk);
        reg_wr_en = 1'b0;
        model_write(ba, d);
        dec_req = 1'b1; dec_addr = a;
        q.push_back(predict(a, 4'd10));
        @(negedge clk);
        dec_req = 1'b0;
    endtask

    // Monitor: compare each registered result with the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && dec_valid) begin
            if (q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R5: actual unexpected result expected none");
            end else begin
                exp_t e;
                string tag;
                e = q.pop_front();
                tag = $sformatf("R%0d", e.req);
                check({tag, " hit"}, {31'b0, dec_hit}, {31'b0, e.hit});
                check({tag, " cs"}, {30'b0, dec_cs}, {30'b0, e.cs});
                check({tag, " offset"}, dec_offset, e.off);
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NCS; k++) m_seg[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 valid", {31'b0, dec_valid}, 32'h0);
        for (int k = 0; k < NCS; k++) reg_check(8'(8'h30 + 4 * k), "R1");
        decode(32'h0000_0000, 4'd1);
        decode(32'h0100_0000, 4'd1);

        // R2: layout and zero low half
        reg_write(8'h30, 32'h0400_FFFF);
        reg_check(8'h30, "R2");
        check("R2 low half", {16'h0, reg_rd_data[15:0]}, 32'h0);
        reg_write(8'h34, 32'h0A04_0000);
        reg_write(8'h38, 32'h140A_0000);
        reg_check(8'h34, "R2");
        reg_check(8'h38, "R2");

        // R5: contiguous windows
        decode(32'h0000_0000, 4'd5);
        decode(32'h01FF_FFFF, 4'd5);
        decode(32'h0200_0000, 4'd5);
        decode(32'h04FF_FFF0, 4'd5);
        decode(32'h0500_0000, 4'd5);
        decode(32'h09FF_FFFF, 4'd5);
        // R9: misses beyond the last window
        decode(32'h0A00_0000, 4'd9);
        decode(32'h8000_0000, 4'd9);

        // R4: closed windows
        reg_write(8'h38, 32'h1414_0000);
        decode(32'h0A00_0000, 4'd4);
        reg_write(8'h38, 32'h1619_0000);
        decode(32'h0B80_0000, 4'd4);
        decode(32'h0C00_0000, 4'd4);

        // R6: overlap, lowest index wins
        reg_write(8'h34, 32'h0800_0000);
        decode(32'h0100_0000, 4'd6);
        decode(32'h0300_0000, 4'd6);

        // R7: limit screening
        reg_write(8'h34, 32'h2104_0000);
        reg_check(8'h34, "R7");
        reg_write(8'h38, 32'h0228_0000);
        reg_check(8'h38, "R7");
        reg_write(8'h38, 32'h201E_0000);
        reg_check(8'h38, "R7");
        decode(32'h0F80_0000, 4'd7);

        // R8: first chip select span cap
        reg_write(8'h30, 32'h1000_0000);
        reg_check(8'h30, "R8");
        reg_write(8'h30, 32'h0F00_0000);
        reg_check(8'h30, "R8");
        decode(32'h0700_0000, 4'd8);
        reg_write(8'h30, 32'h0514_0000);
        reg_check(8'h30, "R8");
        decode(32'h0000_0000, 4'd8);

        // R3: unmapped offsets
        reg_write(8'h2C, 32'h0800_0000);
        reg_write(8'h3C, 32'h0800_0000);
        reg_check(8'h2C, "R3");
        reg_check(8'h3C, "R3");
        reg_check(8'h30, "R3");
        decode(32'h0000_0000, 4'd3);

        // R10: write and decode in the same cycle
        reg_write(8'h30, 32'h0400_0000);
        reg_write(8'h34, 32'h0000_0000);
        write_and_decode(8'h30, 32'h0800_0000, 32'h0280_0000);
        reg_check(8'h30, "R10");

        repeat (4) @(negedge clk);
        check("R5 drained", q.size(), 32'h0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule